// File: doc/BRIEF.md
# Transmit Pad and FCS Inserter

This block sits in the outgoing byte path of an Ethernet transmitter. Frame bytes arrive from the frame buffer with a last-byte marker, and the block passes them on unchanged. When a frame ends it decides how to close the frame. It can append zero bytes to bring a short frame up to the 64-byte minimum. It can also append the four-byte CRC-32 frame check sequence, or it can end the frame with no extra bytes.

Two control inputs steer that decision. The first enables automatic padding. The second suppresses the check sequence. Both are sampled only in the cycle in which the frame's last input byte is accepted, so each frame carries its own choice. Automatic padding also forces the check sequence on, even when suppression is requested. Both ports use valid/ready flow control. The output is a single registered stage. The input is held off while pad or check bytes are being produced.

Top module: `tx_pad_fcs`

## Requirements
- R1: After reset, `out_valid` and `out_last` are 0 and `in_ready` is 1.
- R2: Every accepted input byte appears on the output unchanged and in arrival order.
- R3: With padding enabled at the last byte and fewer than 60 data bytes, bytes of value 00h follow the data until data plus pad total 60, then 4 check bytes follow: 64 bytes in all.
- R4: With padding disabled at the last byte, no pad byte is added, and a frame of any length goes out with only its data bytes plus the check bytes when those are enabled.
- R5: With padding enabled at the last byte, the 4 check bytes are appended even when `fcs_off` is 1.
- R6: The check bytes are the CRC-32 with polynomial 0x04C11DB7, bit-reflected, initial value all ones and final inversion, taken over all data and pad bytes. They are sent least significant byte first.
- R7: `fcs_off` is used only in the cycle the last input byte is accepted; its value on other beats has no effect.
- R8: `pad_en` is used only in the cycle the last input byte is accepted; its value on other beats has no effect.
- R9: A frame of 60 or more data bytes is never padded. The byte counter saturates, so long frames behave the same.
- R10: `out_last` is 1 on the final emitted byte of each frame and on no other byte.
- R11: While `out_valid` is 1 and `out_ready` is 0, the output byte and flags hold. `in_ready` is 0 while pad or check bytes are being generated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts an input byte |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Input byte is the last of its frame |
| pad_en | input | 1 | Automatic padding enable, sampled at the last byte |
| fcs_off | input | 1 | Suppress check bytes, sampled at the last byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte ends the frame |

## Verification
The assertions assume that the downstream side may drop `out_ready` at any time. They also assume that the upstream side keeps `in_valid` and its byte steady until the byte is taken, which the bench's driver does by changing inputs only after an accepted beat. The control inputs are assumed to matter only on the last beat. The stimulus therefore drives the opposite value of `pad_en` and `fcs_off` on every other beat, so any early sampling shows up in the output. Downstream back-pressure follows a pseudo-random pattern on selected frames and a long hold in a directed case.

// File: rtl/tx_pad_fcs_pkg.sv
package tx_pad_fcs_pkg;

  typedef enum logic [1:0] {
    ST_DATA = 2'd0,
    ST_PAD  = 2'd1,
    ST_FCS  = 2'd2
  } tx_state_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  // One byte through the reflected CRC-32, bit by bit.
  function automatic logic [31:0] crc32_step(input logic [31:0] crc, input logic [7:0] b);
    logic [31:0] c;
    c = crc ^ {24'h0, b};
    for (int i = 0; i < 8; i++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/tx_crc32_acc.sv
module tx_crc32_acc
  import tx_pad_fcs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_q
);

  always_ff @(posedge clk) begin
    if (rst || clr) crc_q <= '1;
    else if (en)    crc_q <= crc32_step(crc_q, din);
  end

  // R6: a new frame always starts from the all-ones seed
  a_r6_seed: assert property (@(posedge clk) disable iff (rst) clr |=> (crc_q == 32'hFFFF_FFFF));

endmodule

// File: rtl/tx_len_counter.sv
module tx_len_counter #(
  parameter int MIN_LEN = 60,
  localparam int CNT_W  = $clog2(MIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LEN);

  always_ff @(posedge clk) begin
    if (rst || clr)                cnt_q <= '0;
    else if (inc && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  // R9: the counter never wraps past the minimum length
  a_r9_cnt_sat: assert property (@(posedge clk) disable iff (rst) cnt_q <= CNT_MAX);

endmodule

// File: rtl/tx_pad_fcs.sv
module tx_pad_fcs
  import tx_pad_fcs_pkg::*;
#(
  parameter int MIN_DATA = 60
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       pad_en,
  input  logic       fcs_off,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last
);

  localparam int CNT_W     = $clog2(MIN_DATA + 1);
  localparam int FCS_BYTES = 4;
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(MIN_DATA - 1);
  localparam logic [1:0]       FCS_END    = 2'(FCS_BYTES - 1);

  tx_state_e        state_q;
  logic [1:0]       fcs_idx;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      crc_q;
  logic             adv, take, pad_step, fcs_step;
  logic             frame_open_end, frame_fcs_end;
  logic             want_pad, want_fcs;
  logic [7:0]       fcs_byte;

  assign adv      = !out_valid || out_ready;
  assign in_ready = (state_q == ST_DATA) && adv;
  assign take     = in_valid && in_ready;
  assign pad_step = (state_q == ST_PAD) && adv;
  assign fcs_step = (state_q == ST_FCS) && adv;

  // per-frame decision, taken only on the last input beat
  assign want_pad = pad_en && (cnt_q < LAST_SHORT);
  assign want_fcs = pad_en || !fcs_off;

  assign frame_open_end = take && in_last && !want_fcs;
  assign frame_fcs_end  = fcs_step && (fcs_idx == FCS_END);

  assign fcs_byte = ~crc_q[8*fcs_idx +: 8];

  tx_crc32_acc u_crc (
    .clk   (clk),
    .rst   (rst),
    .clr   (frame_open_end || frame_fcs_end),
    .en    (take || pad_step),
    .din   (pad_step ? 8'h00 : in_data),
    .crc_q (crc_q)
  );

  tx_len_counter #(.MIN_LEN(MIN_DATA)) u_len (
    .clk   (clk),
    .rst   (rst),
    .clr   (frame_open_end || frame_fcs_end),
    .inc   (take || pad_step),
    .cnt_q (cnt_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_DATA;
      fcs_idx   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (adv) begin
      unique case (state_q)
        ST_DATA: begin
          out_valid <= take;
          out_last  <= 1'b0;
          if (take) begin
            out_data <= in_data;
            if (in_last) begin
              if (want_pad)      state_q <= ST_PAD;
              else if (want_fcs) state_q <= ST_FCS;
              else               out_last <= 1'b1;
            end
          end
        end
        ST_PAD: begin
          out_valid <= 1'b1;
          out_data  <= 8'h00;
          out_last  <= 1'b0;
          if (cnt_q == LAST_SHORT) state_q <= ST_FCS;
        end
        ST_FCS: begin
          out_valid <= 1'b1;
          out_data  <= fcs_byte;
          out_last  <= (fcs_idx == FCS_END);
          fcs_idx   <= fcs_idx + 1'b1;
          if (fcs_idx == FCS_END) state_q <= ST_DATA;
        end
        default: state_q <= ST_DATA;
      endcase
    end
  end

  // R11: a stalled output byte holds its value and flags
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R3: each pad step emits a zero byte that does not end the frame
  a_r3_pad_zero: assert property (@(posedge clk) disable iff (rst)
    pad_step |=> (out_valid && out_data == 8'h00 && !out_last));

  // R5: padding always leads into check-byte generation
  a_r5_pad_to_fcs: assert property (@(posedge clk) disable iff (rst)
    pad_step |=> (state_q == ST_PAD || state_q == ST_FCS));

  // R10: only the fourth check byte may close the frame
  a_r10_fcs_last: assert property (@(posedge clk) disable iff (rst)
    (fcs_step && fcs_idx != FCS_END) |=> !out_last);

endmodule

// File: tb/tb_tx_pad_fcs.sv
module tb_tx_pad_fcs;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_last = 1'b0;
  logic       pad_en = 1'b0;
  logic       fcs_off = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_last;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tx_pad_fcs dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .pad_en(pad_en), .fcs_off(fcs_off),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  // vector: len[10:3], pad_en[2], fcs_off[1], back-pressure[0]
  localparam int NV = 10;
  localparam logic [10:0] VEC [NV] = '{
    {8'd10,  1'b1, 1'b0, 1'b0},
    {8'd10,  1'b0, 1'b0, 1'b0},
    {8'd10,  1'b0, 1'b1, 1'b0},
    {8'd5,   1'b1, 1'b1, 1'b1},
    {8'd60,  1'b1, 1'b0, 1'b1},
    {8'd59,  1'b1, 1'b1, 1'b0},
    {8'd100, 1'b1, 1'b1, 1'b0},
    {8'd70,  1'b0, 1'b1, 1'b1},
    {8'd1,   1'b1, 1'b0, 1'b1},
    {8'd61,  1'b0, 1'b0, 1'b0}
  };

  logic       stall_mode = 1'b0;
  logic       hold_low   = 1'b0;
  logic [7:0] lfsr = 8'h5B;
  logic [7:0] rx_b [0:4095];
  logic       rx_l [0:4095];
  int         rx_n = 0;
  logic [7:0] exp_b [0:127];
  int         exp_n;

  // downstream: set ready at the falling edge, then record a transfer
  always @(negedge clk) begin
    out_ready = hold_low ? 1'b0 : (stall_mode ? lfsr[0] : 1'b1);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    #1;
    if (!rst && out_valid && out_ready && rx_n < 4096) begin
      rx_b[rx_n] = out_data;
      rx_l[rx_n] = out_last;
      rx_n++;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // CRC-32 computed MSB-first on reflected input bits, then reversed.
  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c, r;
    logic fb;
    c = '1;
    for (int k = 0; k < n; k++) begin
      for (int b = 0; b < 8; b++) begin
        fb = c[31] ^ exp_b[k][b];
        c = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C11DB7;
      end
    end
    for (int i = 0; i < 32; i++) r[i] = ~c[31-i];
    return r;
  endfunction

  // R7/R8: the controls carry the opposite value on every non-last beat
  task automatic send_frame(input int len, input bit ap, input bit nf, input logic [7:0] seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = seed + 8'(i);
      in_last  = (i == len - 1);
      pad_en   = (i == len - 1) ? ap : ~ap;
      fcs_off  = (i == len - 1) ? nf : ~nf;
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    pad_en   = ~ap;
    fcs_off  = ~nf;
  endtask

  task automatic check_frame(input int base, input int len, input bit ap, input bit nf, input logic [7:0] seed);
    logic [31:0] crc;
    int dn;
    bit withfcs, ok;
    string ltag;
    for (int i = 0; i < len; i++) exp_b[i] = seed + 8'(i);
    dn = (ap && len < 60) ? 60 : len;
    for (int i = len; i < dn; i++) exp_b[i] = 8'h00;
    withfcs = ap || !nf;
    exp_n = dn;
    if (withfcs) begin
      crc = ref_crc(dn);
      for (int i = 0; i < 4; i++) exp_b[dn + i] = crc[8*i +: 8];
      exp_n = dn + 4;
    end
    for (int t = 0; t < 3000 && rx_n < base + exp_n; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    if (ap && len < 60)  ltag = "R3";
    else if (ap && nf)   ltag = "R5";
    else if (len >= 60)  ltag = "R9";
    else                 ltag = "R4";
    check(rx_n == base + exp_n, ltag, $sformatf("frame len %0d byte count", len), rx_n - base, exp_n);
    ok = 1'b1;
    for (int i = 0; i < exp_n && base + i < rx_n; i++) begin
      if (rx_b[base + i] !== exp_b[i]) begin
        ok = 1'b0;
        check(1'b0, (i < len) ? "R2" : (i < dn) ? "R3" : "R6",
              $sformatf("frame len %0d byte %0d", len, i), rx_b[base + i], exp_b[i]);
        break;
      end
    end
    if (ok) check(1'b1, "R2", "bytes", 0, 0);
    ok = 1'b1;
    for (int i = 0; i < exp_n && base + i < rx_n; i++)
      if (rx_l[base + i] !== (i == exp_n - 1)) ok = 1'b0;
    check(ok, "R10", $sformatf("frame len %0d last flag placement", len), ok, 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #2;
    // R1: reset state
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(out_last == 1'b0, "R1", "out_last after reset", out_last, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    for (int v = 0; v < NV; v++) begin
      base = rx_n;
      stall_mode = VEC[v][0];
      send_frame(int'(VEC[v][10:3]), VEC[v][2], VEC[v][1], 8'(v * 37 + 1));
      check_frame(base, int'(VEC[v][10:3]), VEC[v][2], VEC[v][1], 8'(v * 37 + 1));
      stall_mode = 1'b0;
    end

    // R11: output holds under a long stall and the input is blocked
    base = rx_n;
    hold_low = 1'b1;
    @(negedge clk);
    send_frame(1, 1'b0, 1'b1, 8'hA5);
    repeat (5) @(negedge clk);
    #2;
    check(out_valid == 1'b1, "R11", "out_valid held", out_valid, 1);
    check(out_data == 8'hA5, "R11", "out_data held", out_data, 8'hA5);
    check(out_last == 1'b1, "R11", "out_last held", out_last, 1);
    check(in_ready == 1'b0, "R11", "in_ready while output full", in_ready, 0);
    hold_low = 1'b0;
    check_frame(base, 1, 1'b0, 1'b1, 8'hA5);

    // R11: input blocked while pad bytes are generated
    base = rx_n;
    send_frame(2, 1'b1, 1'b0, 8'h30);
    #1;
    check(in_ready == 1'b0, "R11", "in_ready during padding", in_ready, 0);
    check_frame(base, 2, 1'b1, 1'b0, 8'h30);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule